// File: doc/BRIEF.md
# Untagged Indirect Branch Target Table

This block scores indirect branch target predictions. Each resolved indirect branch is presented once, with its own address and the target it actually went to. The block picks one slot of a direct-mapped table from a field of the branch address. It compares the target last stored there with the actual target and reports a mispredict when the two differ. It then stores the actual target in that slot. The table carries no tags and no valid bits. Branches whose addresses select the same slot share one entry, and a new target always replaces the old one.

The slot field starts above a parameterised number of low address bits that are always zero for the instruction encoding in use. It is `SLOT_W` bits wide, which gives 512 slots by default. Each result comes out on a valid-qualified output one clock after the request is accepted. A request that follows on the next cycle and hits the same slot sees the target written by the request before it.

After reset the block sweeps zeros through every slot, one slot per cycle, and holds `req_ready` low while it does so. A lookup of a slot that nothing has written since reset therefore predicts target zero.

Top module: `ind_tgt_table`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly 2^SLOT_W cycles and then rises and stays high until the next reset.
- R2: The slot used is address bits [SKIP_LSB+SLOT_W-1 : SKIP_LSB]. Address bits below or above that field have no effect on the result.
- R3: Every slot holds zero after the reset sweep. The first access to a slot reports a mispredict exactly when its actual target is non-zero.
- R4: `rsp_mispredict` is 1 exactly when the stored target differs from the actual target of the request.
- R5: Every accepted request overwrites its slot with its actual target, whether it hit or missed.
- R6: `rsp_valid` is 1 in the cycle after an accepted request (`req_valid` and `req_ready` both high at a clock edge) and 0 otherwise. `rsp_mispredict` is 0 whenever `rsp_valid` is 0.
- R7: Two back-to-back requests to the same slot: the second is compared against the target written by the first.
- R8: Two different branch addresses that select the same slot share its entry, so each sees the target left by the other.
- R9: A request presented while `req_ready` is low is ignored. It produces no response and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the clearing sweep |
| req_valid | input | 1 | A resolved indirect branch is presented |
| req_ready | output | 1 | High when requests are accepted (low during the sweep) |
| req_addr | input | ADDR_W | Address of the branch |
| req_target | input | TGT_W | Actual target of the branch |
| rsp_valid | output | 1 | Result of the request accepted in the previous cycle |
| rsp_mispredict | output | 1 | Stored target differed from the actual target |

## Verification
The bench uses a 16-slot configuration. A first sweep touches every slot once with a mix of zero and non-zero targets, which shows that the table starts cleared. Several further full sweeps repeat or change each slot's target, which separates a correct hit/miss decision from one that always hits or always misses. Accesses that keep the slot field and vary the bits below and above it check that only the intended field selects the entry and that aliased branches share it. Back-to-back bursts to one slot with alternating targets, plus requests driven during a second reset sweep, test write-before-read ordering and that blocked requests leave no trace.

// File: rtl/itt_pkg.sv
package itt_pkg;

  typedef enum logic [0:0] {
    MODE_SWEEP = 1'b0,
    MODE_RUN   = 1'b1
  } itt_mode_e;

  // Legal range of always-zero low address bits.
  localparam int unsigned SKIP_LSB_MAX = 3;

  function automatic bit skip_ok(input int unsigned skip);
    return skip <= SKIP_LSB_MAX;
  endfunction

endpackage

// File: rtl/itt_sweep_seq.sv
// Walks a zero-write pointer across every slot after reset.
module itt_sweep_seq
  import itt_pkg::*;
#(
  parameter int unsigned SLOT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sweep_busy,
  output logic [SLOT_W-1:0] sweep_slot
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = {SLOT_W{1'b1}};

  itt_mode_e         mode_q;
  logic [SLOT_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SWEEP;
      ptr_q  <= '0;
    end else if (mode_q == MODE_SWEEP) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST_SLOT) begin
        mode_q <= MODE_RUN;
      end
    end
  end

  assign sweep_busy = (mode_q == MODE_SWEEP);
  assign sweep_slot = ptr_q;

endmodule

// File: rtl/itt_entry_array.sv
// Target storage: one write port, one asynchronous read port.
module itt_entry_array #(
  parameter int unsigned SLOT_W = 9,
  parameter int unsigned TGT_W  = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [TGT_W-1:0]  wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [TGT_W-1:0]  rd_data
);

  localparam int unsigned DEPTH = 1 << SLOT_W;

  logic [TGT_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_slot] <= wr_data;
    end
  end

  assign rd_data = store_q[rd_slot];

endmodule

// File: rtl/itt_resp_stage.sv
// Registers the hit/miss verdict for one cycle.
module itt_resp_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic differ,
  output logic rsp_valid,
  output logic rsp_mispredict
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_mispredict <= 1'b0;
    end else begin
      rsp_valid      <= fire;
      rsp_mispredict <= fire & differ;
    end
  end

endmodule

// File: rtl/ind_tgt_table.sv
module ind_tgt_table
  import itt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TGT_W    = 32,
  parameter int unsigned SLOT_W   = 9,
  parameter int unsigned SKIP_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TGT_W-1:0]  req_target,
  output logic              rsp_valid,
  output logic              rsp_mispredict
);

  localparam bit SKIP_LEGAL = skip_ok(SKIP_LSB);
  localparam int unsigned FIELD_TOP = SKIP_LSB + SLOT_W;

  // Slot selection: drop always-zero low bits, keep SLOT_W bits.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[SKIP_LSB +: SLOT_W];
  endfunction

  function automatic logic targets_differ(input logic [TGT_W-1:0] held,
                                          input logic [TGT_W-1:0] seen);
    return held != seen;
  endfunction

  // Named internal events (observed by the checker).
  logic              clear_busy;
  logic [SLOT_W-1:0] clear_slot;
  logic              acc_fire;
  logic [SLOT_W-1:0] lk_slot;
  logic [TGT_W-1:0]  lk_stored;
  logic              lk_miss;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [TGT_W-1:0]  wr_data;

  itt_sweep_seq #(.SLOT_W(SLOT_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .sweep_busy (clear_busy),
    .sweep_slot (clear_slot)
  );

  assign req_ready = ~clear_busy;
  assign acc_fire  = req_valid & req_ready;
  assign lk_slot   = slot_of(req_addr);

  // Sweep owns the write port; otherwise each accepted lookup writes back.
  always_comb begin
    if (clear_busy) begin
      wr_en   = 1'b1;
      wr_slot = clear_slot;
      wr_data = '0;
    end else begin
      wr_en   = acc_fire;
      wr_slot = lk_slot;
      wr_data = req_target;
    end
  end

  itt_entry_array #(.SLOT_W(SLOT_W), .TGT_W(TGT_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_data (wr_data),
    .rd_slot (lk_slot),
    .rd_data (lk_stored)
  );

  assign lk_miss = targets_differ(lk_stored, req_target);

  itt_resp_stage u_resp (
    .clk            (clk),
    .rst_n          (rst_n),
    .fire           (acc_fire),
    .differ         (lk_miss),
    .rsp_valid      (rsp_valid),
    .rsp_mispredict (rsp_mispredict)
  );

  if (!SKIP_LEGAL || FIELD_TOP > ADDR_W) begin : g_bad_cfg
    $error("ind_tgt_table: slot field does not fit the address");
  end

endmodule

// File: rtl/ind_tgt_table_chk.sv
module ind_tgt_table_chk #(
  parameter int unsigned TGT_W  = 32,
  parameter int unsigned SLOT_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [TGT_W-1:0]  req_target,
  input logic              rsp_valid,
  input logic              rsp_mispredict,
  input logic              clear_busy,
  input logic              acc_fire,
  input logic [TGT_W-1:0]  lk_stored,
  input logic              wr_en,
  input logic [SLOT_W-1:0] wr_slot,
  input logic [TGT_W-1:0]  wr_data
);

  // R1
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_busy && $past(clear_busy) && $past(rst_n))
      |-> wr_slot == SLOT_W'($past(wr_slot) + 1'b1));

  // R3
  sweep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_busy |-> (wr_en && wr_data == '0));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_busy |-> (!req_ready && !acc_fire));

  // R5
  write_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (wr_en && wr_data == req_target));

  // R6
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> rsp_valid);

  // R6
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> (!rsp_valid && !rsp_mispredict));

  // R4
  miss_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> rsp_mispredict == $past(lk_stored != req_target));

endmodule

bind ind_tgt_table ind_tgt_table_chk #(
  .TGT_W  (TGT_W),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .req_target     (req_target),
  .rsp_valid      (rsp_valid),
  .rsp_mispredict (rsp_mispredict),
  .clear_busy     (clear_busy),
  .acc_fire       (acc_fire),
  .lk_stored      (lk_stored),
  .wr_en          (wr_en),
  .wr_slot        (wr_slot),
  .wr_data        (wr_data)
);

// File: tb/sim_ind_tgt_table.sv
`timescale 1ns/1ps
module sim_ind_tgt_table;

  localparam int AW    = 16;
  localparam int TW    = 12;
  localparam int SW    = 4;
  localparam int SKIP  = 2;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_target = '0;
  logic          rsp_valid;
  logic          rsp_mispredict;

  int checks = 0;
  int errors = 0;
  logic [TW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  ind_tgt_table #(.ADDR_W(AW), .TGT_W(TW), .SLOT_W(SW), .SKIP_LSB(SKIP)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_target     (req_target),
    .rsp_valid      (rsp_valid),
    .rsp_mispredict (rsp_mispredict)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Slot computed arithmetically: divide away the skipped bits, modulo depth.
  function automatic int slot_idx(input int a);
    return (a / (1 << SKIP)) % DEPTH;
  endfunction

  // Called at a negedge; drives a request, checks its response one negedge later.
  task automatic issue(input int a, input int t, input string req);
    int  s;
    bit  exp_miss;
    s = slot_idx(a);
    exp_miss = (int'(model[s]) != t);
    model[s] = TW'(t);
    req_valid  = 1'b1;
    req_addr   = AW'(a);
    req_target = TW'(t);
    @(negedge clk);
    chk({req, " R6 valid"}, int'(rsp_valid), 1);
    chk({req, " mispredict"}, int'(rsp_mispredict), int'(exp_miss));
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
    chk("R6 no request no response", int'(rsp_valid), 0);
    chk("R6 quiet flag", int'(rsp_mispredict), 0);
  endtask

  // Reset, optionally poking requests during the sweep; counts ready-low cycles.
  task automatic do_reset(input bit poke);
    int low;
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 reset state valid", int'(rsp_valid), 0);
    chk("R1 reset state ready", int'(req_ready), 0);
    rst_n = 1'b1;
    low = 0;
    while (!req_ready && low < 4 * DEPTH) begin
      low++;
      if (poke && low <= 3) begin
        req_valid  = 1'b1;
        req_addr   = AW'(5 << SKIP);
        req_target = TW'(12'h5A5);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      chk("R9 no response while busy", int'(rsp_valid), 0);
    end
    chk("R1 sweep length", low, DEPTH);
    req_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    idle();

    // R3: first touch of each slot compares against zero.
    for (int s = 0; s < DEPTH; s++) begin
      issue((s << SKIP) | (s << 9), (s % 3 == 0) ? 0 : s * 101 + 7, "R3 first touch");
    end
    idle();

    // R4/R5: full sweeps, targets repeat across round pairs.
    for (int r = 0; r < 6; r++) begin
      for (int s = 0; s < DEPTH; s++) begin
        issue(s << SKIP, ((s * 37 + (r / 2) * 11) & 12'hFFF), "R4 R5 sweep");
      end
      idle();
    end

    // R2/R8: vary bits outside the field, same slot shared.
    for (int s = 0; s < DEPTH; s++) begin
      issue((s << SKIP) | 3, 100 + s, "R2 low bits");
      issue((s << SKIP) | ((s + 1) << 12), 100 + s, "R8 alias same target");
      issue((s << SKIP) | (7 << 8), 200 + s, "R8 alias new target");
      issue(s << SKIP, 200 + s, "R2 R8 readback");
    end
    idle();

    // R7: back-to-back same slot, alternating targets.
    for (int k = 0; k < 8; k++) begin
      issue(9 << SKIP, (k % 2 == 0) ? 12'hABC : 12'h123, "R7 back to back");
    end
    issue(9 << SKIP, 12'h123, "R7 repeat hit");
    idle();

    // R9 + R3: requests during a second sweep are ignored; table cleared.
    do_reset(1'b1);
    issue(5 << SKIP, 12'h5A5, "R9 blocked request left no entry");
    issue(6 << SKIP, 0, "R3 cleared slot");
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule